// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block performs 32-bit signed and unsigned saturating arithmetic in a single combinational pass. It supports signed add and subtract, a flag-only signed add, doubling, unsigned add and subtract, clamping a value to a programmable bit position, and a dual 16-bit lane form of that clamp. The selected result appears on `res_o` in the same cycle as the opcode and operands.

Any operation that saturates, or that detects an overflow, raises an overflow event. A single registered flag collects these events. Once set, the flag stays high until a synchronous clear strobe or reset. An execution pipeline can use it to accumulate saturation across a sequence of instructions and read it out later.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (flag-only add) returns A+B modulo 2^32 unchanged. It raises the overflow event when A and B have the same sign and the sum's sign differs from A's.
- R2: Opcode 1 (signed saturating add) uses the same overflow test as R1. Opcode 2 (signed saturating subtract, A−B) flags overflow when A and B differ in sign and the difference's sign differs from A's. On overflow the result is 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative. Otherwise the wrapped value is returned.
- R3: Opcode 3 doubles A. Signed A ≥ 0x40000000 gives 0x7FFFFFFF with the event. Signed A ≤ 0xC0000000 gives 0x80000000 with the event. Any other A gives A shifted left by one, with no event.
- R4: Opcode 4 (unsigned add) gives 0xFFFFFFFF with the event when the sum carries out of 32 bits. Opcode 5 (unsigned subtract, A−B) gives 0 with the event when B > A. Otherwise each returns the exact value with no event.
- R5: Opcode 6 clamps signed A to position n = `pos_i`. Let T = A arithmetically shifted right by n. If T > 0 the result is 2^n−1. If T < −1 the result is the bitwise inverse of 2^n−1. Either case raises the event. Otherwise A passes through unchanged. Legal n is 0..30; n = 31 always passes A through.
- R6: Opcode 7 clamps A, read as signed, to the unsigned range [0, 2^n−1] for n = 0..31. A negative A gives 0. A above 2^n−1 gives 2^n−1. Either clamp raises the event.
- R7: Opcodes 8 (signed) and 9 (unsigned) apply the R5 and R6 rules to bits 15:0 and bits 31:16 of A. Each half is sign-extended and clamped on its own, and the low 16 bits of each lane result land in the same half of `res_o`. A clamp in either lane raises the event.
- R8: `flag_o` is a register. It goes high at the first rising clock edge at which the event is present. It stays high until cleared, and it never rises without an event.
- R9: `flag_clr_i` sampled high at a rising edge forces `flag_o` low, even when an event occurs in the same cycle. Active-low `rst_n` clears the flag asynchronously.
- R10: Opcodes 10..15 give a result of 0 and raise no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select, encodings per R1–R10 |
| a_i | input | 32 | Operand A, the only operand of opcodes 3 and 6..9 |
| b_i | input | 32 | Operand B for opcodes 0..2, 4 and 5 |
| pos_i | input | 5 | Saturation bit position n for opcodes 6..9 |
| flag_clr_i | input | 1 | Synchronous clear strobe for the sticky flag |
| res_o | output | 32 | Combinational result |
| flag_o | output | 1 | Sticky saturation flag |

## Verification
Assertions check the sticky-flag rules on every cycle: set on an event, hold, clear priority, and no spurious rise. On every cycle they also check that any saturating signed or unsigned result lies on the proper rail, that an unsigned clamp never exceeds 2^n−1, and that unused opcodes stay quiet. The assertions cannot show the exact arithmetic boundaries: 0x40000000 against 0x3FFFFFFF for doubling, T = −1 against T = −2 in the signed clamp, and which lane trips the flag in the dual forms. Only the bench's directed vectors exercise those.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LW    = 16;
  localparam int unsigned PW    = 5;
  localparam int unsigned OPW   = 4;
  localparam int unsigned LANES = DW / LW;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [OPW-1:0] {
    OP_ADDQ  = 4'd0,
    OP_QADD  = 4'd1,
    OP_QSUB  = 4'd2,
    OP_QDBL  = 4'd3,
    OP_UQADD = 4'd4,
    OP_UQSUB = 4'd5,
    OP_SSAT  = 4'd6,
    OP_USAT  = 4'd7,
    OP_SSAT2 = 4'd8,
    OP_USAT2 = 4'd9
  } sat_op_e;

  typedef struct packed {
    word_t val;
    logic  ovf;
  } sat_res_t;

  localparam word_t POS_RAIL = {1'b0, {(DW-1){1'b1}}};
  localparam word_t NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

  function automatic word_t f_rail(input word_t a);
    return a[DW-1] ? NEG_RAIL : POS_RAIL;
  endfunction

  function automatic sat_res_t f_sadd(input word_t a, input word_t b);
    sat_res_t r;
    word_t    s;
    s     = a + b;
    r.ovf = (s[DW-1] ^ a[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
    r.val = r.ovf ? f_rail(a) : s;
    return r;
  endfunction

  function automatic sat_res_t f_ssub(input word_t a, input word_t b);
    sat_res_t r;
    word_t    d;
    d     = a - b;
    r.ovf = (d[DW-1] ^ a[DW-1]) & (a[DW-1] ^ b[DW-1]);
    r.val = r.ovf ? f_rail(a) : d;
    return r;
  endfunction

  function automatic sat_res_t f_dbl(input word_t a);
    sat_res_t r;
    logic     hi_trip;
    logic     lo_trip;
    hi_trip = ~a[DW-1] & a[DW-2];
    lo_trip = a[DW-1] & (~a[DW-2] | (a[DW-3:0] == '0));
    r.ovf   = hi_trip | lo_trip;
    if (hi_trip)      r.val = POS_RAIL;
    else if (lo_trip) r.val = NEG_RAIL;
    else              r.val = {a[DW-2:0], 1'b0};
    return r;
  endfunction

  function automatic sat_res_t f_uadd(input word_t a, input word_t b);
    sat_res_t      r;
    logic [DW:0]   s;
    s     = {1'b0, a} + {1'b0, b};
    r.ovf = s[DW];
    r.val = s[DW] ? '1 : s[DW-1:0];
    return r;
  endfunction

  function automatic sat_res_t f_usub(input word_t a, input word_t b);
    sat_res_t r;
    r.ovf = (b > a);
    r.val = r.ovf ? '0 : (a - b);
    return r;
  endfunction

  function automatic word_t f_mask(input logic [PW-1:0] n);
    return (word_t'(1) << n) - word_t'(1);
  endfunction

  function automatic sat_res_t f_sclamp(input word_t v, input logic [PW-1:0] n);
    sat_res_t r;
    word_t    t;
    logic     above;
    logic     below;
    t     = $signed(v) >>> n;
    above = ~t[DW-1] & (t != '0);
    below = t[DW-1] & (t != '1);
    r.ovf = above | below;
    if (above)      r.val = f_mask(n);
    else if (below) r.val = ~f_mask(n);
    else            r.val = v;
    return r;
  endfunction

  function automatic sat_res_t f_uclamp(input word_t v, input logic [PW-1:0] n);
    sat_res_t r;
    word_t    lim;
    lim = f_mask(n);
    if (v[DW-1]) begin
      r.ovf = 1'b1;
      r.val = '0;
    end else if (v > lim) begin
      r.ovf = 1'b1;
      r.val = lim;
    end else begin
      r.ovf = 1'b0;
      r.val = v;
    end
    return r;
  endfunction
endpackage

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  word_t          a_i,
  input  word_t          b_i,
  output word_t          res_o,
  output logic           ovf_o
);
  sat_res_t t;

  always_comb begin
    t     = '0;
    res_o = '0;
    ovf_o = 1'b0;
    case (op_i)
      OP_ADDQ: begin
        t     = f_sadd(a_i, b_i);
        res_o = a_i + b_i;
        ovf_o = t.ovf;
      end
      OP_QADD:  begin t = f_sadd(a_i, b_i); res_o = t.val; ovf_o = t.ovf; end
      OP_QSUB:  begin t = f_ssub(a_i, b_i); res_o = t.val; ovf_o = t.ovf; end
      OP_QDBL:  begin t = f_dbl(a_i);       res_o = t.val; ovf_o = t.ovf; end
      OP_UQADD: begin t = f_uadd(a_i, b_i); res_o = t.val; ovf_o = t.ovf; end
      OP_UQSUB: begin t = f_usub(a_i, b_i); res_o = t.val; ovf_o = t.ovf; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
  import sat_pkg::*;
(
  input  word_t          v_i,
  input  logic [PW-1:0]  pos_i,
  input  logic           sgn_i,
  output word_t          res_o,
  output logic           ovf_o
);
  sat_res_t t;

  always_comb begin
    t     = sgn_i ? f_sclamp(v_i, pos_i) : f_uclamp(v_i, pos_i);
    res_o = t.val;
    ovf_o = t.ovf;
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> flag_o); // R8
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o && !set_i |=> !flag_o); // R8
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_i,
  input  logic [31:0]    a_i,
  input  logic [31:0]    b_i,
  input  logic [4:0]     pos_i,
  input  logic           flag_clr_i,
  output logic [31:0]    res_o,
  output logic           flag_o
);
  word_t      arith_res;
  logic       arith_ovf;
  word_t      word_res;
  logic       word_ovf;
  word_t      pair_res;
  logic [LANES-1:0] lane_ovf;
  word_t      lane_full [LANES];
  logic       sat_evt;

  sat_arith u_arith (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (arith_res),
    .ovf_o (arith_ovf)
  );

  sat_clamp u_word (
    .v_i   (a_i),
    .pos_i (pos_i),
    .sgn_i (op_i == OP_SSAT),
    .res_o (word_res),
    .ovf_o (word_ovf)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    word_t lane_in;
    assign lane_in = {{(DW-LW){a_i[g*LW+LW-1]}}, a_i[g*LW +: LW]};
    sat_clamp u_clamp (
      .v_i   (lane_in),
      .pos_i (pos_i),
      .sgn_i (op_i == OP_SSAT2),
      .res_o (lane_full[g]),
      .ovf_o (lane_ovf[g])
    );
    assign pair_res[g*LW +: LW] = lane_full[g][LW-1:0];
  end

  always_comb begin
    res_o   = '0;
    sat_evt = 1'b0;
    case (op_i)
      OP_ADDQ, OP_QADD, OP_QSUB, OP_QDBL, OP_UQADD, OP_UQSUB: begin
        res_o   = arith_res;
        sat_evt = arith_ovf;
      end
      OP_SSAT, OP_USAT: begin
        res_o   = word_res;
        sat_evt = word_ovf;
      end
      OP_SSAT2, OP_USAT2: begin
        res_o   = pair_res;
        sat_evt = |lane_ovf;
      end
      default: ;
    endcase
  end

  sat_sticky u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sat_evt),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  AST_SIGNED_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {OP_QADD, OP_QSUB, OP_QDBL}) && sat_evt
      |-> (res_o == 32'h7FFF_FFFF) || (res_o == 32'h8000_0000)); // R2
  AST_UADD_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UQADD) && sat_evt |-> res_o == 32'hFFFF_FFFF); // R4
  AST_USUB_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UQSUB) && sat_evt |-> res_o == 32'h0); // R4
  AST_USAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_USAT) |-> res_o <= ((32'h1 << pos_i) - 32'h1)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd10) |-> (res_o == 32'h0) && !sat_evt); // R10
endmodule

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd15;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [4:0]  pos = '0;
  logic        clr = 1'b0;
  logic [31:0] res;
  logic        flag;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sat_alu u_sat_alu (
    .clk (clk), .rst_n (rst_n), .op_i (op), .a_i (a), .b_i (b),
    .pos_i (pos), .flag_clr_i (clr), .res_o (res), .flag_o (flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] va,
                     input logic [31:0] vb, input logic [4:0] n,
                     input logic [31:0] er, input logic ef);
    @(negedge clk); clr = 1'b1; op = 4'd15;
    @(negedge clk); clr = 1'b0; op = o; a = va; b = vb; pos = n;
    #1 check({tag, " result"}, res, er);
    @(negedge clk); op = 4'd15;
    check({tag, " flag"}, {31'b0, flag}, {31'b0, ef});
  endtask

  task automatic t_reset;
    #1 check("R8 reset flag", {31'b0, flag}, 32'h0);
    check("R10 reset idle result", res, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_flag_add;
    run("R1 wrap pos", 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b1);
    run("R1 plain", 4'd0, 32'h5, 32'h3, 5'd0, 32'h8, 1'b0);
    run("R1 wrap neg", 4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
  endtask

  task automatic t_sat_addsub;
    run("R2 add hi", 4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h7FFFFFFF, 1'b1);
    run("R2 add lo", 4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    run("R2 add ok", 4'd1, 32'h10, 32'h20, 5'd0, 32'h30, 1'b0);
    run("R2 sub lo", 4'd2, 32'h80000000, 32'h1, 5'd0, 32'h80000000, 1'b1);
    run("R2 sub hi", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
    run("R2 sub ok", 4'd2, 32'h5, 32'h7, 5'd0, 32'hFFFFFFFE, 1'b0);
  endtask

  task automatic t_double;
    run("R3 at hi edge", 4'd3, 32'h40000000, 32'h0, 5'd0, 32'h7FFFFFFF, 1'b1);
    run("R3 below hi", 4'd3, 32'h3FFFFFFF, 32'h0, 5'd0, 32'h7FFFFFFE, 1'b0);
    run("R3 at lo edge", 4'd3, 32'hC0000000, 32'h0, 5'd0, 32'h80000000, 1'b1);
    run("R3 above lo", 4'd3, 32'hC0000001, 32'h0, 5'd0, 32'h80000002, 1'b0);
    run("R3 minus one", 4'd3, 32'hFFFFFFFF, 32'h0, 5'd0, 32'hFFFFFFFE, 1'b0);
  endtask

  task automatic t_unsigned;
    run("R4 add carry", 4'd4, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    run("R4 add exact", 4'd4, 32'hFFFFFFF0, 32'hF, 5'd0, 32'hFFFFFFFF, 1'b0);
    run("R4 sub under", 4'd5, 32'h3, 32'h5, 5'd0, 32'h0, 1'b1);
    run("R4 sub equal", 4'd5, 32'h5, 32'h5, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_ssat;
    run("R5 above", 4'd6, 32'h100, 32'h0, 5'd7, 32'h7F, 1'b1);
    run("R5 below", 4'd6, 32'hFFFFFF00, 32'h0, 5'd7, 32'hFFFFFF80, 1'b1);
    run("R5 top edge", 4'd6, 32'h7F, 32'h0, 5'd7, 32'h7F, 1'b0);
    run("R5 bottom edge", 4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0);
    run("R5 n0", 4'd6, 32'h1, 32'h0, 5'd0, 32'h0, 1'b1);
    run("R5 n30", 4'd6, 32'h7FFFFFFF, 32'h0, 5'd30, 32'h3FFFFFFF, 1'b1);
  endtask

  task automatic t_usat;
    run("R6 negative", 4'd7, 32'hFFFFFFFF, 32'h0, 5'd8, 32'h0, 1'b1);
    run("R6 above", 4'd7, 32'h100, 32'h0, 5'd8, 32'hFF, 1'b1);
    run("R6 edge", 4'd7, 32'hFF, 32'h0, 5'd8, 32'hFF, 1'b0);
    run("R6 n31", 4'd7, 32'h7FFFFFFF, 32'h0, 5'd31, 32'h7FFFFFFF, 1'b0);
    run("R6 n0", 4'd7, 32'h1, 32'h0, 5'd0, 32'h0, 1'b1);
  endtask

  task automatic t_lanes;
    run("R7 signed both", 4'd8, 32'h0100FF00, 32'h0, 5'd7, 32'h007FFF80, 1'b1);
    run("R7 signed none", 4'd8, 32'h00100020, 32'h0, 5'd7, 32'h00100020, 1'b0);
    run("R7 signed low only", 4'd8, 32'h00058000, 32'h0, 5'd7, 32'h0005FF80, 1'b1);
    run("R7 unsigned both", 4'd9, 32'hFFFF0100, 32'h0, 5'd8, 32'h000000FF, 1'b1);
    run("R7 unsigned none", 4'd9, 32'h00FF0001, 32'h0, 5'd8, 32'h00FF0001, 1'b0);
    run("R7 unsigned high only", 4'd9, 32'h80000010, 32'h0, 5'd15, 32'h00000010, 1'b1);
  endtask

  task automatic t_idle;
    run("R10 op12", 4'd12, 32'h7FFFFFFF, 32'h1, 5'd3, 32'h0, 1'b0);
    run("R10 op15", 4'd15, 32'hFFFFFFFF, 32'h0, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_sticky;
    @(negedge clk); clr = 1'b1; op = 4'd15;
    @(negedge clk); clr = 1'b0; op = 4'd1; a = 32'h7FFFFFFF; b = 32'h1;
    #1 check("R8 not before edge", {31'b0, flag}, 32'h0);
    @(negedge clk); op = 4'd0; a = 32'h1; b = 32'h1;
    check("R8 set after edge", {31'b0, flag}, 32'h1);
    @(negedge clk); op = 4'd15;
    check("R8 held", {31'b0, flag}, 32'h1);
    @(negedge clk);
    check("R8 held idle", {31'b0, flag}, 32'h1);
  endtask

  task automatic t_clear;
    @(negedge clk); op = 4'd4; a = 32'hFFFFFFFF; b = 32'h1;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; op = 4'd15;
    check("R9 clear wins", {31'b0, flag}, 32'h0);
    op = 4'd5; a = 32'h0; b = 32'h1;
    @(negedge clk); op = 4'd15;
    check("R9 set again", {31'b0, flag}, 32'h1);
    rst_n = 1'b0;
    #1 check("R9 reset clears", {31'b0, flag}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_flag_add();
    t_sat_addsub();
    t_double();
    t_unsigned();
    t_ssat();
    t_usat();
    t_lanes();
    t_idle();
    t_sticky();
    t_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule